// File: doc/BRIEF.md
# Parallel Port Control Register

This block is the host-side control register of a PC-style parallel port. The host reaches it over a plain byte-wide register bus. A write strobe and a read strobe each qualify a base-relative offset. The register's low bits drive the printer-side control lines, three of them active-low and one passed through without inversion. One bit enables an interrupt that is raised when the peripheral's acknowledge line rises. Another bit, together with the port mode taken from a separate configuration input, decides whether the data lines drive outward or receive.

The acknowledge line is asynchronous to the host clock. It passes through a synchronizer before edge detection. The interrupt is a level that the host clears by reading the status offset or by turning the enable off. No data stream passes through this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `ppc_control`

## Requirements
- R1: After reset the control register reads 0x00, strobe_n_o=1, autofd_n_o=1, init_n_o=0, select_n_o=1, irq_o=0 and data_in_o=0.
- R2: A write at offset 2 stores data bits 5:0, and the stored value is visible on bus_rdata_o while bus_addr_i is 2. Any other offset reads 0x00.
- R3: Bits 7 and 6 of the control register read as 0 regardless of what was written to them.
- R4: Output mapping from the control bits: strobe_n_o = NOT bit0, autofd_n_o = NOT bit1, init_n_o = bit2, select_n_o = NOT bit3. Writing 1 to bit3 therefore selects the printer.
- R5: With bit4 (interrupt enable) at 1, a rising edge on ack_i asserts irq_o at the third rising clock edge after ack_i goes high, and not before.
- R6: A falling edge of ack_i, or ack_i held high, does not raise irq_o.
- R7: With bit4 at 0, irq_o is 0 from the clock edge after the enable was cleared. A rising edge of ack_i while disabled is not remembered for a later enable.
- R8: Once asserted, irq_o stays at 1 until a read strobe at offset 1 (status) or until the enable is cleared. It drops at the clock edge that takes the read.
- R9: In printer mode (mode_i=00), data_in_o is 0 whatever the value of bit5.
- R10: In bidirectional (01), EPP (10) and ECP (11) modes, data_in_o equals bit5: 0 means the port drives data out, 1 means it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Port mode: 00 printer, 01 bidirectional, 10 EPP, 11 ECP |
| bus_wr_i | input | 1 | Register write strobe, one cycle |
| bus_rd_i | input | 1 | Register read strobe, one cycle |
| bus_addr_i | input | 3 | Base-relative register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed offset |
| ack_i | input | 1 | Peripheral acknowledge level, asynchronous |
| strobe_n_o | output | 1 | Data strobe, active low |
| autofd_n_o | output | 1 | Auto line feed, active low |
| init_n_o | output | 1 | Initialise line, driven from bit2 without inversion |
| select_n_o | output | 1 | Printer select, active low |
| irq_o | output | 1 | Host interrupt request level |
| data_in_o | output | 1 | 1 when the data lines receive, 0 when they drive |

## Verification
The register path is tried with a table of written bytes that mixes set and clear patterns on every control bit, crossed with all four modes. A mapping or inversion error on one line cannot hide behind another, and the printer-mode override is told apart from a plain copy of bit5. The interrupt path is tried with an enabled rising edge, a falling edge, a held-high level, an edge arriving while disabled, and both clearing routes. These separate edge detection from level detection, show whether a disabled edge is dropped or remembered, and show which clear route takes effect. The cycle on which the interrupt first appears is sampled on both sides, which pins the synchronizer depth.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    MODE_PRINTER = 2'b00,
    MODE_BIDIR   = 2'b01,
    MODE_EPP     = 2'b10,
    MODE_ECP     = 2'b11
  } port_mode_e;

  localparam int CTRL_BITS = 6;
  localparam int BUS_W     = 8;

  typedef struct packed {
    logic dir_in;
    logic irq_en;
    logic select;
    logic init;
    logic autofd;
    logic strobe;
  } ctrl_t;
endpackage

// File: rtl/ppc_ctrl_reg.sv
module ppc_ctrl_reg
  import ppc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CTRL_OFS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output ctrl_t             ctrl_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);
  localparam int PAD_W = BUS_W - CTRL_BITS;

  ctrl_t ctrl_q;
  logic  hit;

  assign hit = (addr_i == OFS);

  always_ff @(posedge clk) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (wr_i && hit) ctrl_q <= ctrl_t'(wdata_i[CTRL_BITS-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = {{PAD_W{1'b0}}, ctrl_q};
  end

  assign ctrl_o = ctrl_q;

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit) |=> (ctrl_q == $past(wdata_i[CTRL_BITS-1:0])));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[BUS_W-1:CTRL_BITS] == '0));
endmodule

// File: rtl/ppc_ack_irq.sv
module ppc_ack_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic rise;
  logic pend_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ack_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (!irq_en_i)        pend_q <= 1'b0;
    else if (rise)             pend_q <= 1'b1;
    else if (clr_i)            pend_q <= 1'b0;
  end

  assign irq_o = pend_q;

  // R5
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && irq_en_i) |=> irq_o);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i) |=> !irq_o);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise) |=> !irq_o);

  // R8
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_en_i && !clr_i) |=> irq_o);
endmodule

// File: rtl/ppc_dir_resolve.sv
module ppc_dir_resolve
  import ppc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       dir_bit_i,
  output logic       data_in_o
);
  port_mode_e mode;
  assign mode = port_mode_e'(mode_i);

  always_comb begin
    case (mode)
      MODE_PRINTER: data_in_o = 1'b0;
      default:      data_in_o = dir_bit_i;
    endcase
  end

  // R9
  printer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !data_in_o);

  // R10
  other_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b00) |-> (data_in_o == dir_bit_i));
endmodule

// File: rtl/ppc_control.sv
module ppc_control
  import ppc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_OFS    = 2,
  parameter int STAT_OFS    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ack_i,
  output logic              strobe_n_o,
  output logic              autofd_n_o,
  output logic              init_n_o,
  output logic              select_n_o,
  output logic              irq_o,
  output logic              data_in_o
);
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(STAT_OFS);

  ctrl_t ctrl;
  logic  stat_rd;

  assign stat_rd = bus_rd_i && (bus_addr_i == STAT);

  ppc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (bus_rdata_o)
  );

  ppc_ack_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .irq_en_i (ctrl.irq_en),
    .clr_i    (stat_rd),
    .irq_o    (irq_o)
  );

  ppc_dir_resolve u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .dir_bit_i (ctrl.dir_in),
    .data_in_o (data_in_o)
  );

  assign strobe_n_o = ~ctrl.strobe;
  assign autofd_n_o = ~ctrl.autofd;
  assign init_n_o   =  ctrl.init;
  assign select_n_o = ~ctrl.select;

  // R4
  select_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(CTRL_OFS)) |=> (select_n_o == !$past(bus_wdata_i[3])));
endmodule

// File: tb/tb_ppc_control.sv
`timescale 1ns/100ps
module tb_ppc_control;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic       strobe_n, autofd_n, init_n, select_n, irq, data_in;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  ppc_control dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ack_i(ack),
    .strobe_n_o(strobe_n), .autofd_n_o(autofd_n), .init_n_o(init_n),
    .select_n_o(select_n), .irq_o(irq), .data_in_o(data_in)
  );

  // {mode, write byte, expected readback, expected {strobe_n,autofd_n,init_n,select_n,data_in}}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00, 5'b11010},
    {2'd0, 8'hFF, 8'h3F, 5'b00100},
    {2'd1, 8'h20, 8'h20, 5'b11011},
    {2'd2, 8'h20, 8'h20, 5'b11011},
    {2'd3, 8'hE5, 8'h25, 5'b01111},
    {2'd1, 8'h0A, 8'h0A, 5'b10000},
    {2'd0, 8'h28, 8'h28, 5'b11000},
    {2'd3, 8'h10, 8'h10, 5'b11010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read_status();
    @(negedge clk);
    rd = 1'b1; addr = 3'd1;
    @(negedge clk);
    rd = 1'b0; addr = 3'd2;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    addr = 3'd2;
    @(negedge clk);
    // R1
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outputs", {strobe_n, autofd_n, init_n, select_n, data_in}, 5'b11010);
    chk("R1 irq", irq, 1'b0);

    // R2 R3 R4 R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][22:21];
      bus_write(3'd2, VEC[v][20:13]);
      chk("R2/R3 readback", rdata, VEC[v][12:5]);
      chk("R4/R9/R10 outputs", {strobe_n, autofd_n, init_n, select_n, data_in}, VEC[v][4:0]);
    end

    // R2: other offset reads zero
    bus_write(3'd2, 8'h3F);
    addr = 3'd5;
    #1;
    chk("R2 other offset", rdata, 8'h00);
    addr = 3'd2;
    // R9: printer mode overrides bit5, R10 ECP follows
    mode = 2'b00; #1;
    chk("R9 printer dir", data_in, 1'b0);
    mode = 2'b11; #1;
    chk("R10 ecp dir", data_in, 1'b1);
    mode = 2'b00;

    // R5: enabled rising edge, exact latency
    bus_write(3'd2, 8'h10);
    ack = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not early", irq, 1'b0);
    @(negedge clk);
    chk("R5 asserted", irq, 1'b1);
    // R8: holds through ack falling and idle
    ack = 1'b0;
    wait_cyc(6);
    chk("R8 holds", irq, 1'b1);
    bus_read_status();
    chk("R8 status read clears", irq, 1'b0);

    // R6: falling edge happened above; ack held high after a clear
    wait_cyc(4);
    chk("R6 falling edge", irq, 1'b0);
    ack = 1'b1;
    wait_cyc(5);
    chk("R5 second edge", irq, 1'b1);
    bus_read_status();
    wait_cyc(6);
    chk("R6 held high", irq, 1'b0);
    ack = 1'b0;
    wait_cyc(4);

    // R7: edge while disabled is dropped
    bus_write(3'd2, 8'h00);
    ack = 1'b1;
    wait_cyc(6);
    chk("R7 disabled", irq, 1'b0);
    bus_write(3'd2, 8'h10);
    wait_cyc(4);
    chk("R7 not remembered", irq, 1'b0);
    ack = 1'b0;
    wait_cyc(4);

    // R8/R7: clearing the enable drops the request
    ack = 1'b1;
    wait_cyc(5);
    chk("R5 third edge", irq, 1'b1);
    bus_write(3'd2, 8'h00);
    @(negedge clk);
    chk("R7 enable clear drops", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule